// File: doc/BRIEF.md
# EPROM Mode Decoder with ID Readout

This block is a synthesizable behavioural model of a byte-wide programmable read-only memory. It is meant to sit in a testbench or an emulator in place of the real part. On every clock edge it samples the active-low chip select and output gate, a program-voltage flag and a flag that marks a high voltage on address line nine. From these it picks one operating state. The state then decides whether the bidirectional data bus is driven and with which byte.

The storage array holds 2^ADDR_W bytes. Reset and the erase input return every byte to all ones. A program cycle can only clear bits, because the array stores the AND of the old byte and the byte on the bus. A write happens once, on the clock edge where the state machine moves into PROGRAM from any other state. Staying in PROGRAM writes nothing more, so a new write needs a fresh select pulse.

When the high-voltage flag is set during a read, the model returns identifier bytes in place of array data. Address bit 0 chooses between the maker byte and the device byte. Bit 7 of each identifier byte is an odd-parity bit over the whole byte.

State machine. The states are STANDBY, READ, OUT_OFF, PROGRAM, VERIFY, INHIBIT and IDREAD. The next state depends only on the sampled pins, so any state can move to any other in one edge:
- STANDBY: select high and no program voltage.
- READ: select low and gate low, without the high-voltage flag.
- IDREAD: select low and gate low, with the high-voltage flag.
- OUT_OFF: select low, gate high, no program voltage.
- PROGRAM: select low, gate high, with program voltage.
- VERIFY: select high, gate low, with program voltage.
- INHIBIT: select high, gate high, with program voltage.

The one transition that has a side effect is "enter PROGRAM" (from any state other than PROGRAM). That transition performs the write.

Top module: `prom_model`

## Requirements
- R1: On the clock edge after select and gate are both sampled low with the high-voltage flag low, the model drives the byte stored at the current address, whatever the program-voltage flag is.
- R2: With select sampled high and no program voltage, the bus is not driven, whatever the gate is.
- R3: With select low, gate high and no program voltage, the bus is not driven and the array does not change.
- R4: With program voltage, select low and gate high, the bus is not driven. On the edge that enters this state, the byte on the bus is written to the current address.
- R5: With program voltage, select high and gate low, the model drives the byte stored at the current address.
- R6: With program voltage and both select and gate high, the bus is not driven and the array does not change.
- R7: With the high-voltage flag set and select and gate low, address bit 0 = 0 drives the maker byte (01h by default). Address bit 0 = 1 drives the device byte (10h by default). All other address bits are zero.
- R8: Bit 7 of each identifier byte makes the count of ones in the 8-bit byte odd.
- R9: In the identifier state with any address bit above bit 0 set, the error output goes high and the bus drives 00h. Otherwise the error output is low.
- R10: After reset, and on the edge after erase is sampled high, every byte reads FFh.
- R11: A write stores the old byte ANDed with the bus byte. Bits only go from one to zero, and repeating the same write leaves the byte unchanged.
- R12: Holding the PROGRAM state over several edges writes only once. A change of the bus byte while the state is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset; fills the array with ones |
| erase | input | 1 | Synchronous whole-array erase to ones |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| vpp_on | input | 1 | Program voltage present |
| hv_a9 | input | 1 | High voltage present on address line nine |
| addr | input | ADDR_W | Byte address |
| dq | inout | 8 | Bidirectional data bus |
| bus_drive | output | 1 | High while the model drives dq |
| id_err | output | 1 | Identifier read with non-zero upper address bits |

## Verification
Each mode takes effect one rising edge after the pins are sampled. Read data then follows the address without further delay. A write lands on the edge that enters PROGRAM, so its result can only be seen after a later edge has moved the state into READ or VERIFY. The bench therefore changes pins on the falling edge and waits for one rising edge. It samples bus_drive, id_err and dq two nanoseconds after that edge, and it reads dq only while bus_drive is high. It checks writes after a separate read step.

// File: rtl/prom_pkg.sv
package prom_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        M_STANDBY,
        M_READ,
        M_OUT_OFF,
        M_PROGRAM,
        M_VERIFY,
        M_INHIBIT,
        M_IDREAD
    } mode_e;

    // Top bit makes the population count of the whole byte odd.
    function automatic logic [BYTE_W-1:0] odd_par_byte(input logic [BYTE_W-2:0] v);
        return {~(^v), v};
    endfunction

endpackage

// File: rtl/prom_mode_fsm.sv
module prom_mode_fsm
    import prom_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_on,
    input  logic  hv_a9,
    output mode_e mode_q,
    output logic  prog_edge
);

    mode_e mode_d;

    // Next-state decode from sampled pins.
    always_comb begin
        unique case ({ce_n, oe_n})
            2'b00:   mode_d = hv_a9  ? M_IDREAD  : M_READ;
            2'b01:   mode_d = vpp_on ? M_PROGRAM : M_OUT_OFF;
            2'b10:   mode_d = vpp_on ? M_VERIFY  : M_STANDBY;
            default: mode_d = vpp_on ? M_INHIBIT : M_STANDBY;
        endcase
        prog_edge = (mode_d == M_PROGRAM) && (mode_q != M_PROGRAM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_STANDBY;
        else        mode_q <= mode_d;
    end

    // R12: a write strobe never occurs while PROGRAM is held.
    p_single_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_PROGRAM) |-> !prog_edge);

endmodule

// File: rtl/prom_array.sv
module prom_array
    import prom_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (erase) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[addr] <= cells[addr] & wr_data;
        end
    end

    assign rd_data = cells[addr];

    // R11: outside erase, no cell ever gains a one.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell_chk
        p_clear_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(erase)) |-> ((cells[g] & ~$past(cells[g])) == '0));
    end

endmodule

// File: rtl/prom_id_source.sv
module prom_id_source
    import prom_pkg::*;
#(
    parameter logic [BYTE_W-2:0] MAKER_CODE  = 7'h01,
    parameter logic [BYTE_W-2:0] DEVICE_CODE = 7'h10
) (
    input  logic              sel_device,
    output logic [BYTE_W-1:0] id_byte
);

    always_comb begin
        id_byte = sel_device ? odd_par_byte(DEVICE_CODE) : odd_par_byte(MAKER_CODE);
        // R8: identifier byte carries odd parity.
        p_id_parity_r8: assert ((^id_byte) == 1'b1);
    end

endmodule

// File: rtl/prom_model.sv
module prom_model
    import prom_pkg::*;
#(
    parameter int                ADDR_W      = 6,
    parameter logic [BYTE_W-2:0] MAKER_CODE  = 7'h01,
    parameter logic [BYTE_W-2:0] DEVICE_CODE = 7'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_on,
    input  logic              hv_a9,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [BYTE_W-1:0] dq,
    output logic              bus_drive,
    output logic              id_err
);

    mode_e             mode_q;
    logic              prog_edge;
    logic [BYTE_W-1:0] rd_data;
    logic [BYTE_W-1:0] id_byte;
    logic [BYTE_W-1:0] dout;
    logic              upper_nz;

    prom_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vpp_on    (vpp_on),
        .hv_a9     (hv_a9),
        .mode_q    (mode_q),
        .prog_edge (prog_edge)
    );

    prom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (prog_edge),
        .addr    (addr),
        .wr_data (dq),
        .rd_data (rd_data)
    );

    prom_id_source #(.MAKER_CODE(MAKER_CODE), .DEVICE_CODE(DEVICE_CODE)) u_id (
        .sel_device (addr[0]),
        .id_byte    (id_byte)
    );

    assign upper_nz = |addr[ADDR_W-1:1];

    // Output process driven by the registered state.
    always_comb begin
        bus_drive = 1'b0;
        id_err    = 1'b0;
        dout      = '0;
        unique case (mode_q)
            M_READ, M_VERIFY: begin
                bus_drive = 1'b1;
                dout      = rd_data;
            end
            M_IDREAD: begin
                bus_drive = 1'b1;
                if (upper_nz) id_err = 1'b1;
                else          dout   = id_byte;
            end
            default: ;
        endcase
    end

    assign dq = bus_drive ? dout : 'z;

    p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !ce_n && !oe_n && !hv_a9) |-> (bus_drive && !id_err));

    p_standby_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ce_n && !vpp_on) |-> !bus_drive);

    p_sel_gate_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !ce_n && oe_n) |-> !bus_drive);

    p_verify_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && vpp_on && ce_n && !oe_n) |-> bus_drive);

    p_inhibit_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && vpp_on && ce_n && oe_n) |-> !bus_drive);

    p_id_err_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |-> ($past(hv_a9 && !ce_n && !oe_n) && bus_drive));

endmodule

// File: tb/test_prom_model.sv
module test_prom_model;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          erase = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          vpp_on = 1'b0;
    logic          hv_a9 = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          tb_en = 1'b0;
    logic [7:0]    tb_data = 8'h00;
    wire  [7:0]    dq;
    logic          bus_drive;
    logic          id_err;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    assign dq = tb_en ? tb_data : 8'bz;

    always #10 clk = ~clk;

    prom_model #(.ADDR_W(AW)) i_prom_model (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase     (erase),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vpp_on    (vpp_on),
        .hv_a9     (hv_a9),
        .addr      (addr),
        .dq        (dq),
        .bus_drive (bus_drive),
        .id_err    (id_err)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive pins at the falling edge, let one rising edge latch them, sample after it.
    task automatic step(input logic c, input logic o, input logic v, input logic h,
                        input logic [AW-1:0] a, input logic drv, input logic [7:0] d);
        @(negedge clk);
        ce_n = c; oe_n = o; vpp_on = v; hv_a9 = h; addr = a;
        tb_en = drv; tb_data = d;
        @(posedge clk);
        #2;
    endtask

    task automatic read_byte(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        step(1'b0, 1'b0, 1'b0, 1'b0, a, 1'b0, 8'h00);
        chk({req, " drive"}, {7'd0, bus_drive}, 8'h01);
        chk({req, " data"}, dq, exp);
    endtask

    task automatic program_pulse(input logic [AW-1:0] a, input logic [7:0] d);
        step(1'b1, 1'b1, 1'b1, 1'b0, a, 1'b1, d);
        step(1'b0, 1'b1, 1'b1, 1'b0, a, 1'b1, d);
        chk("R4 no drive in program", {7'd0, bus_drive}, 8'h00);
        step(1'b1, 1'b1, 1'b1, 1'b0, a, 1'b0, d);
    endtask

    task automatic t_reset_state;
        chk("R2 reset no drive", {7'd0, bus_drive}, 8'h00);
        read_byte("R10 reset fill", 6'd5, 8'hFF);
        read_byte("R1 read top", 6'd63, 8'hFF);
    endtask

    task automatic t_standby;
        step(1'b1, 1'b0, 1'b0, 1'b0, 6'd3, 1'b0, 8'h00);
        chk("R2 standby gate low", {7'd0, bus_drive}, 8'h00);
        step(1'b1, 1'b1, 1'b0, 1'b0, 6'd3, 1'b0, 8'h00);
        chk("R2 standby gate high", {7'd0, bus_drive}, 8'h00);
    endtask

    task automatic t_program;
        program_pulse(6'd3, 8'hA5);
        read_byte("R4 written byte", 6'd3, 8'hA5);
        read_byte("R1 neighbour untouched", 6'd2, 8'hFF);
    endtask

    task automatic t_and;
        program_pulse(6'd3, 8'h0F);
        read_byte("R11 and result", 6'd3, 8'h05);
        program_pulse(6'd3, 8'h0F);
        read_byte("R11 repeat idempotent", 6'd3, 8'h05);
        program_pulse(6'd3, 8'hFF);
        read_byte("R11 no one restored", 6'd3, 8'h05);
    endtask

    task automatic t_hold;
        step(1'b1, 1'b1, 1'b1, 1'b0, 6'd4, 1'b1, 8'h3C);
        step(1'b0, 1'b1, 1'b1, 1'b0, 6'd4, 1'b1, 8'h3C);
        step(1'b0, 1'b1, 1'b1, 1'b0, 6'd4, 1'b1, 8'h00);
        step(1'b0, 1'b1, 1'b1, 1'b0, 6'd4, 1'b1, 8'h81);
        chk("R12 held no drive", {7'd0, bus_drive}, 8'h00);
        read_byte("R12 single write", 6'd4, 8'h3C);
    endtask

    task automatic t_out_off;
        step(1'b0, 1'b1, 1'b0, 1'b0, 6'd5, 1'b1, 8'h00);
        chk("R3 no drive", {7'd0, bus_drive}, 8'h00);
        step(1'b0, 1'b1, 1'b0, 1'b0, 6'd5, 1'b1, 8'h00);
        read_byte("R3 array unchanged", 6'd5, 8'hFF);
    endtask

    task automatic t_inhibit;
        step(1'b1, 1'b1, 1'b1, 1'b0, 6'd6, 1'b1, 8'h00);
        chk("R6 no drive", {7'd0, bus_drive}, 8'h00);
        step(1'b1, 1'b1, 1'b1, 1'b0, 6'd6, 1'b1, 8'h00);
        read_byte("R6 array unchanged", 6'd6, 8'hFF);
    endtask

    task automatic t_verify;
        step(1'b1, 1'b0, 1'b1, 1'b0, 6'd3, 1'b0, 8'h00);
        chk("R5 drive", {7'd0, bus_drive}, 8'h01);
        chk("R5 data", dq, 8'h05);
        step(1'b1, 1'b0, 1'b1, 1'b0, 6'd4, 1'b0, 8'h00);
        chk("R5 data other addr", dq, 8'h3C);
    endtask

    task automatic t_id;
        step(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 1'b0, 8'h00);
        chk("R7 maker drive", {7'd0, bus_drive}, 8'h01);
        chk("R7 maker byte", dq, 8'h01);
        chk("R8 maker parity", {7'd0, ^dq}, 8'h01);
        chk("R9 no err maker", {7'd0, id_err}, 8'h00);
        step(1'b0, 1'b0, 1'b0, 1'b1, 6'd1, 1'b0, 8'h00);
        chk("R7 device byte", dq, 8'h10);
        chk("R8 device parity", {7'd0, ^dq}, 8'h01);
        chk("R9 no err device", {7'd0, id_err}, 8'h00);
    endtask

    task automatic t_id_err;
        step(1'b0, 1'b0, 1'b0, 1'b1, 6'd2, 1'b0, 8'h00);
        chk("R9 err flag", {7'd0, id_err}, 8'h01);
        chk("R9 err drive", {7'd0, bus_drive}, 8'h01);
        chk("R9 err data", dq, 8'h00);
        step(1'b0, 1'b0, 1'b0, 1'b1, 6'd33, 1'b0, 8'h00);
        chk("R9 err high bit", {7'd0, id_err}, 8'h01);
        read_byte("R1 flag clear", 6'd2, 8'hFF);
        chk("R9 err clear in read", {7'd0, id_err}, 8'h00);
    endtask

    task automatic t_erase;
        @(negedge clk);
        erase = 1'b1;
        @(negedge clk);
        erase = 1'b0;
        read_byte("R10 erase addr3", 6'd3, 8'hFF);
        read_byte("R10 erase addr4", 6'd4, 8'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        t_reset_state();
        t_standby();
        t_program();
        t_and();
        t_hold();
        t_out_off();
        t_inhibit();
        t_verify();
        t_id();
        t_id_err();
        t_erase();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule